// File: doc/BRIEF.md
# Board-Sensing Automatic Chess Clock

This block is a two-player game clock that hands the turn over by itself. It watches a vector of square-occupancy sensors, one bit per square of the board, where a 1 means a piece rests on that square. A piece being set down on any square ends the mover's turn and starts the opponent's clock. Lifting pieces never switches the turn. This gives the "a move is finished when a piece is put down" rule, and a capture (two pieces picked up, one put down) counts as one move.

The sensor vector is asynchronous to the clock. It passes through a multi-flop synchronizer and is then compared with a registered copy of the previous sample, which finds the empty-to-occupied changes. A placement switches the active side once, however many squares rise in that cycle. After each switch, a lockout window of a few cycles ignores further placements, which rejects sensor bounce. Each side has a countdown of whole seconds. It is loaded at reset and decremented by an external one-second tick pulse, and only while that side is active. When either countdown reaches zero, the flag of that side latches, and the whole clock freezes until reset.

The run input pauses the game. While it is low, placements do not switch the turn and the timers do not count. Placements made during a pause are consumed and do not take effect later. The synchronous reset loads both timers and makes white the side to move. It also adopts the board as it is at that moment, so that pieces already standing on the board cause no switch.

Top module: `chess_turn_clock`

## Requirements
- R1: While reset is high and after it, active_o is 0 (white), both time outputs equal START_SECONDS and both flags are 0. Squares already occupied during reset cause no switch afterwards.
- R2: A board bit changing from 0 to 1 (1 = occupied) toggles active_o (0 = white, 1 = black). With SYNC_STAGES = 2, the new value appears after the third rising edge following the change of the input, and not after the second.
- R3: Board bits changing from 1 to 0 never change active_o, whether one square or several squares are vacated in the same cycle.
- R4: A capture, made of two lifts followed by one placement, produces exactly one toggle of active_o.
- R5: Several board bits rising in the same cycle produce a single toggle.
- R6: After a toggle, a rising board bit reaches the edge detector on one of the next LOCKOUT_CYCLES rising edges is ignored, and it is not applied later. A placement seen after the window toggles normally.
- R7: While run_i is 0, active_o and both time outputs hold their values, whatever the board and tick_i do.
- R8: A tick_i pulse, sampled with run_i = 1 and no flag set, decrements the active side's time by exactly 1 and leaves the other side's time unchanged.
- R9: When a side's time reaches 0, its flag output goes to 1 on the same edge and stays at 1 until reset. From then on both times and active_o are frozen, and placements and ticks have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run_i | input | 1 | Game running; 0 pauses switching and counting |
| tick_i | input | 1 | One-cycle pulse once per second |
| board_i | input | SQUARES | Square occupancy, 1 = piece present, asynchronous |
| active_o | output | 1 | Side to move: 0 = white, 1 = black |
| white_time_o | output | TIME_W | White's remaining seconds |
| black_time_o | output | TIME_W | Black's remaining seconds |
| white_flag_o | output | 1 | White's time has run out (sticky) |
| black_flag_o | output | 1 | Black's time has run out (sticky) |

## Verification
The properties check the following on every cycle:
- the turn and the timers hold while the game is paused;
- each timer steps down by exactly one and only on a qualifying tick for its side;
- the flags are sticky and imply a zero time, and the freeze after a flag holds;
- a counter held beside the design shows that no two toggles come closer than the lockout window.

Some behaviours depend on what happened at the sensor inputs several synchronizer stages earlier, and only the bench's scenarios show them:
- a lift never switches the turn;
- a capture switches once;
- a placement during a pause is lost;
- the exact edge on which a placement takes effect.

// File: rtl/turn_clock_pkg.sv
package turn_clock_pkg;

   typedef enum logic {
      SIDE_WHITE = 1'b0,
      SIDE_BLACK = 1'b1
   } side_t;

   localparam int unsigned NUM_SIDES = 2;

   function automatic side_t other_side(input side_t s);
      return (s == SIDE_WHITE) ? SIDE_BLACK : SIDE_WHITE;
   endfunction

endpackage

// File: rtl/occupancy_sync.sv
module occupancy_sync #(
   parameter int unsigned WIDTH  = 64,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] raw_i,
   output logic [WIDTH-1:0] sync_o
);

   logic [WIDTH-1:0] stage_q [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("occupancy_sync: STAGES must be at least 2");
      end
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
               stage_q[g] <= raw_i;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) begin
                  stage_q[g] <= raw_i;
               end else begin
                  stage_q[g] <= stage_q[g-1];
               end
            end
         end
      end
   endgenerate

   assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/placement_detect.sv
module placement_detect #(
   parameter int unsigned WIDTH    = 64,
   parameter bit          USE_TREE = 1'b1,
   parameter int unsigned GROUP_W  = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] raw_i,
   input  logic [WIDTH-1:0] sync_i,
   output logic             placed_o
);

   localparam int unsigned NGROUP = (WIDTH + GROUP_W - 1) / GROUP_W;
   localparam int unsigned PAD_W  = NGROUP * GROUP_W;

   logic [WIDTH-1:0] prev_q;
   logic [WIDTH-1:0] rise_vec;

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_q <= raw_i;
      end else begin
         prev_q <= sync_i;
      end
   end

   assign rise_vec = sync_i & ~prev_q;

   generate
      if (GROUP_W < 1) begin : g_bad_group
         $error("placement_detect: GROUP_W must be at least 1");
      end
      if (USE_TREE) begin : g_tree
         logic [PAD_W-1:0]  rise_pad;
         logic [NGROUP-1:0] group_any;
         always_comb begin
            rise_pad = '0;
            rise_pad[WIDTH-1:0] = rise_vec;
         end
         for (genvar g = 0; g < NGROUP; g++) begin : g_group
            assign group_any[g] = |rise_pad[g*GROUP_W +: GROUP_W];
         end
         assign placed_o = |group_any;
      end else begin : g_flat
         assign placed_o = |rise_vec;
      end
   endgenerate

endmodule

// File: rtl/turn_arbiter.sv
module turn_arbiter
   import turn_clock_pkg::*;
#(
   parameter int unsigned LOCKOUT_CYCLES = 4
) (
   input  logic  clk,
   input  logic  rst,
   input  logic  placed_i,
   input  logic  run_i,
   input  logic  frozen_i,
   output side_t active_o
);

   logic  lock_free;
   logic  toggle;
   side_t active_q;

   generate
      if (LOCKOUT_CYCLES > 0) begin : g_lock
         localparam int unsigned LOCK_W = $clog2(LOCKOUT_CYCLES + 1);
         localparam logic [LOCK_W-1:0] LOCK_LOAD = LOCK_W'(LOCKOUT_CYCLES);
         logic [LOCK_W-1:0] lock_q;
         always_ff @(posedge clk) begin
            if (rst) begin
               lock_q <= '0;
            end else if (toggle) begin
               lock_q <= LOCK_LOAD;
            end else if (lock_q != '0) begin
               lock_q <= lock_q - 1'b1;
            end
         end
         assign lock_free = (lock_q == '0);
      end else begin : g_nolock
         assign lock_free = 1'b1;
      end
   endgenerate

   assign toggle = placed_i && run_i && !frozen_i && lock_free;

   always_ff @(posedge clk) begin
      if (rst) begin
         active_q <= SIDE_WHITE;
      end else if (toggle) begin
         active_q <= other_side(active_q);
      end
   end

   assign active_o = active_q;

endmodule

// File: rtl/player_timer.sv
module player_timer #(
   parameter int unsigned START_SECONDS = 300,
   parameter int unsigned TIME_W        = 9
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              count_en_i,
   output logic [TIME_W-1:0] time_o,
   output logic              flag_o
);

   localparam logic [TIME_W-1:0] LOAD_VAL = TIME_W'(START_SECONDS);
   localparam logic [TIME_W-1:0] LAST_SEC = TIME_W'(1);

   logic [TIME_W-1:0] time_q;
   logic              flag_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         time_q <= LOAD_VAL;
         flag_q <= 1'b0;
      end else if (count_en_i && time_q != '0) begin
         time_q <= time_q - 1'b1;
         if (time_q == LAST_SEC) begin
            flag_q <= 1'b1;
         end
      end
   end

   assign time_o = time_q;
   assign flag_o = flag_q;

endmodule

// File: rtl/chess_turn_clock.sv
module chess_turn_clock
   import turn_clock_pkg::*;
#(
   parameter int unsigned SQUARES        = 64,
   parameter int unsigned SYNC_STAGES    = 2,
   parameter int unsigned LOCKOUT_CYCLES = 4,
   parameter int unsigned START_SECONDS  = 300,
   parameter int unsigned TIME_W         = 9,
   parameter bit          USE_TREE       = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               run_i,
   input  logic               tick_i,
   input  logic [SQUARES-1:0] board_i,
   output logic               active_o,
   output logic [TIME_W-1:0]  white_time_o,
   output logic [TIME_W-1:0]  black_time_o,
   output logic               white_flag_o,
   output logic               black_flag_o
);

   localparam longint unsigned TIME_MAX = (64'd1 << TIME_W) - 1;

   generate
      if (SQUARES < 1) begin : g_bad_squares
         $error("chess_turn_clock: SQUARES must be at least 1");
      end
      if (START_SECONDS < 1) begin : g_bad_start
         $error("chess_turn_clock: START_SECONDS must be at least 1");
      end
      if (longint'(START_SECONDS) > TIME_MAX) begin : g_bad_width
         $error("chess_turn_clock: TIME_W too narrow for START_SECONDS");
      end
   endgenerate

   logic [SQUARES-1:0] board_sync;
   logic               placed;
   logic               frozen;
   side_t              active;
   logic [TIME_W-1:0]  time_w [NUM_SIDES];
   logic               flag_w [NUM_SIDES];

   occupancy_sync #(
      .WIDTH  (SQUARES),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk    (clk),
      .rst    (rst),
      .raw_i  (board_i),
      .sync_o (board_sync)
   );

   placement_detect #(
      .WIDTH    (SQUARES),
      .USE_TREE (USE_TREE),
      .GROUP_W  (8)
   ) u_detect (
      .clk      (clk),
      .rst      (rst),
      .raw_i    (board_i),
      .sync_i   (board_sync),
      .placed_o (placed)
   );

   assign frozen = flag_w[0] | flag_w[1];

   turn_arbiter #(
      .LOCKOUT_CYCLES (LOCKOUT_CYCLES)
   ) u_turn (
      .clk      (clk),
      .rst      (rst),
      .placed_i (placed),
      .run_i    (run_i),
      .frozen_i (frozen),
      .active_o (active)
   );

   generate
      for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
         logic count_en;
         assign count_en = tick_i && run_i && !frozen && (active == side_t'(s));
         player_timer #(
            .START_SECONDS (START_SECONDS),
            .TIME_W        (TIME_W)
         ) u_timer (
            .clk        (clk),
            .rst        (rst),
            .count_en_i (count_en),
            .time_o     (time_w[s]),
            .flag_o     (flag_w[s])
         );
      end
   endgenerate

   assign active_o     = active;
   assign white_time_o = time_w[0];
   assign black_time_o = time_w[1];
   assign white_flag_o = flag_w[0];
   assign black_flag_o = flag_w[1];

endmodule

// File: rtl/turn_clock_checker.sv
module turn_clock_checker #(
   parameter int unsigned LOCKOUT_CYCLES = 4,
   parameter int unsigned TIME_W         = 9
) (
   input logic              clk,
   input logic              rst,
   input logic              run_i,
   input logic              tick_i,
   input logic              active_o,
   input logic [TIME_W-1:0] white_time_o,
   input logic [TIME_W-1:0] black_time_o,
   input logic              white_flag_o,
   input logic              black_flag_o
);

   localparam int unsigned CW = $clog2(LOCKOUT_CYCLES + 2);

   logic          prev_active;
   logic [CW-1:0] gap_cnt;
   logic          any_flag;
   logic          white_step;
   logic          black_step;

   assign any_flag   = white_flag_o || black_flag_o;
   assign white_step = tick_i && run_i && !any_flag && !active_o && white_time_o != '0;
   assign black_step = tick_i && run_i && !any_flag && active_o && black_time_o != '0;

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_active <= 1'b0;
         gap_cnt     <= '0;
      end else begin
         prev_active <= active_o;
         if (active_o != prev_active) begin
            gap_cnt <= CW'(LOCKOUT_CYCLES);
         end else if (gap_cnt != '0) begin
            gap_cnt <= gap_cnt - 1'b1;
         end
      end
   end

   p_lockout_gap_r6: assert property (@(posedge clk) disable iff (rst)
      (active_o != prev_active) |-> (gap_cnt == '0));

   p_hold_paused_r7: assert property (@(posedge clk) disable iff (rst)
      !run_i |=> ($stable(active_o) && $stable(white_time_o) && $stable(black_time_o)));

   p_white_step_r8: assert property (@(posedge clk) disable iff (rst)
      white_step |=> (white_time_o == $past(white_time_o) - 1'b1));

   p_white_hold_r8: assert property (@(posedge clk) disable iff (rst)
      !white_step |=> $stable(white_time_o));

   p_black_step_r8: assert property (@(posedge clk) disable iff (rst)
      black_step |=> (black_time_o == $past(black_time_o) - 1'b1));

   p_black_hold_r8: assert property (@(posedge clk) disable iff (rst)
      !black_step |=> $stable(black_time_o));

   p_white_sticky_r9: assert property (@(posedge clk) disable iff (rst)
      white_flag_o |=> white_flag_o);

   p_black_sticky_r9: assert property (@(posedge clk) disable iff (rst)
      black_flag_o |=> black_flag_o);

   p_flag_zero_r9: assert property (@(posedge clk) disable iff (rst)
      (white_flag_o |-> white_time_o == '0) and (black_flag_o |-> black_time_o == '0));

   p_frozen_r9: assert property (@(posedge clk) disable iff (rst)
      any_flag |=> ($stable(active_o) && $stable(white_time_o) && $stable(black_time_o)));

endmodule

bind chess_turn_clock turn_clock_checker #(
   .LOCKOUT_CYCLES (LOCKOUT_CYCLES),
   .TIME_W         (TIME_W)
) u_checker (
   .clk          (clk),
   .rst          (rst),
   .run_i        (run_i),
   .tick_i       (tick_i),
   .active_o     (active_o),
   .white_time_o (white_time_o),
   .black_time_o (black_time_o),
   .white_flag_o (white_flag_o),
   .black_flag_o (black_flag_o)
);

// File: tb/chess_turn_clock_test.sv
`timescale 1ns/1ps
module chess_turn_clock_test;

   localparam int SQ    = 64;
   localparam int SYNC  = 2;
   localparam int LOCK  = 3;
   localparam int START = 5;
   localparam int TW    = 9;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          run_i = 1'b0;
   logic          tick_i = 1'b0;
   logic [SQ-1:0] board_i = 64'h0000_0000_0000_FFFF;
   logic          active_o;
   logic [TW-1:0] white_time_o;
   logic [TW-1:0] black_time_o;
   logic          white_flag_o;
   logic          black_flag_o;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   chess_turn_clock #(
      .SQUARES        (SQ),
      .SYNC_STAGES    (SYNC),
      .LOCKOUT_CYCLES (LOCK),
      .START_SECONDS  (START),
      .TIME_W         (TW)
   ) uut (
      .clk          (clk),
      .rst          (rst),
      .run_i        (run_i),
      .tick_i       (tick_i),
      .board_i      (board_i),
      .active_o     (active_o),
      .white_time_o (white_time_o),
      .black_time_o (black_time_o),
      .white_flag_o (white_flag_o),
      .black_flag_o (black_flag_o)
   );

   // behavioural reference: sensor delay line, turn, lockout and timers
   logic [SQ-1:0] m_line [$];
   logic [SQ-1:0] m_seen;
   int            m_active;
   int            m_time [2];
   int            m_flag [2];
   int            m_lock;
   bit            m_ok = 1'b0;

   always @(posedge clk) begin
      if (rst) begin
         m_line.delete();
         for (int i = 0; i < SYNC; i++) m_line.push_back(board_i);
         m_seen   = board_i;
         m_active = 0;
         m_time   = '{START, START};
         m_flag   = '{0, 0};
         m_lock   = 0;
         m_ok     = 1'b1;
      end else begin
         logic [SQ-1:0] arrived;
         bit            over;
         bit            flip;
         arrived = m_line[0];
         void'(m_line.pop_front());
         m_line.push_back(board_i);
         over = (m_flag[0] != 0) || (m_flag[1] != 0);
         flip = ((arrived & ~m_seen) != '0) && run_i && !over && (m_lock == 0);
         m_seen = arrived;
         if (flip) m_lock = LOCK;
         else if (m_lock > 0) m_lock--;
         if (tick_i && run_i && !over && m_time[m_active] > 0) begin
            m_time[m_active]--;
            if (m_time[m_active] == 0) m_flag[m_active] = 1;
         end
         if (flip) m_active = 1 - m_active;
      end
   end

   task automatic chk(input string tag, input longint act, input longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (m_ok && !rst && !done) begin
         chk("R2 model active_o", active_o, m_active);
         chk("R8 model white_time_o", white_time_o, m_time[0]);
         chk("R8 model black_time_o", black_time_o, m_time[1]);
         chk("R9 model white_flag_o", white_flag_o, m_flag[0]);
         chk("R9 model black_flag_o", black_flag_o, m_flag[1]);
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_tick();
      @(negedge clk);
      tick_i = 1'b1;
      @(negedge clk);
      tick_i = 1'b0;
   endtask

   initial begin
      // R1: reset state with pieces already on the board
      cyc(4);
      chk("R1 active in reset", active_o, 0);
      chk("R1 white time in reset", white_time_o, START);
      chk("R1 black time in reset", black_time_o, START);
      rst = 1'b0;
      run_i = 1'b1;
      cyc(8);
      chk("R1 no toggle from initial board", active_o, 0);
      chk("R1 flags clear", {white_flag_o, black_flag_o}, 0);

      // R3: lifting one square, then four at once
      board_i[0] = 1'b0;
      cyc(8);
      chk("R3 single lift", active_o, 0);
      board_i[11:8] = 4'h0;
      cyc(8);
      chk("R3 multi lift", active_o, 0);

      // R2: placement takes effect after the third rising edge
      board_i[0] = 1'b1;
      cyc(2);
      chk("R2 not yet after two edges", active_o, 0);
      cyc(1);
      chk("R2 toggled after three edges", active_o, 1);
      cyc(8);

      // R4: capture = two lifts then one placement
      board_i[1] = 1'b0;
      cyc(6);
      board_i[2] = 1'b0;
      cyc(6);
      board_i[20] = 1'b1;
      cyc(8);
      chk("R4 capture toggles once", active_o, 0);

      // R5: three squares rising together
      board_i[32:30] = 3'b111;
      cyc(8);
      chk("R5 simultaneous rises toggle once", active_o, 1);

      // R6: bounce inside lockout is ignored, later placement works
      board_i[40] = 1'b1;
      cyc(1);
      board_i[41] = 1'b1;
      cyc(10);
      chk("R6 second rise inside lockout ignored", active_o, 0);
      board_i[42] = 1'b1;
      cyc(8);
      chk("R6 placement after lockout toggles", active_o, 1);

      // R7: paused game ignores placements and ticks
      run_i = 1'b0;
      board_i[43] = 1'b1;
      cyc(8);
      chk("R7 no toggle while paused", active_o, 1);
      pulse_tick();
      cyc(2);
      chk("R7 black time holds while paused", black_time_o, START);
      run_i = 1'b1;
      cyc(8);
      chk("R7 paused placement not applied later", active_o, 1);

      // R8: ticks decrement only the active side
      pulse_tick();
      cyc(2);
      chk("R8 black decremented", black_time_o, START - 1);
      chk("R8 white unchanged", white_time_o, START);
      board_i[44] = 1'b1;
      cyc(8);
      chk("R8 turn to white", active_o, 0);
      pulse_tick();
      pulse_tick();
      cyc(2);
      chk("R8 white after two ticks", white_time_o, START - 2);

      // R9: white runs out, everything freezes
      pulse_tick();
      pulse_tick();
      pulse_tick();
      cyc(2);
      chk("R9 white time zero", white_time_o, 0);
      chk("R9 white flag set", white_flag_o, 1);
      chk("R9 black flag clear", black_flag_o, 0);
      board_i[45] = 1'b1;
      cyc(8);
      chk("R9 no toggle after flag", active_o, 0);
      pulse_tick();
      cyc(2);
      chk("R9 black time frozen", black_time_o, START - 1);
      chk("R9 flag sticky", white_flag_o, 1);

      // R1: second reset restores the start state
      @(negedge clk);
      rst = 1'b1;
      cyc(3);
      rst = 1'b0;
      cyc(8);
      chk("R1 active after re-reset", active_o, 0);
      chk("R1 times after re-reset", {white_time_o, black_time_o}, {TW'(START), TW'(START)});
      chk("R1 flags after re-reset", {white_flag_o, black_flag_o}, 0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog R1 actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule